// File: doc/BRIEF.md
# Parking External Bus Arbiter

This block decides who owns a shared synchronous external bus: the on-chip side (instruction fetches and data accesses) or a single external master. Ownership changes through a request, grant and busy handshake. When nobody else needs the bus it stays parked on the on-chip side, so an on-chip access can drive the busy line and start at once, without a request phase. An external request is weighed against the priority of the on-chip access in flight. Instruction accesses rank 3, data accesses rank 4 and a parked, idle on-chip side ranks 0. The external side's rank comes from a 3-bit configuration input.

The arbiter also covers three special cases. It keeps the bus through on-chip sequences flagged atomic. It forces a one-cycle hand-off to the external side when an on-chip transfer is retried. It issues a one-clock retry to the external master when that master reaches on-chip space while an on-chip request is waiting. All request, busy and retry inputs are sampled on the rising clock edge. All outputs come from registers. Reset is asynchronous and active-low, and is released through a two-stage synchronizer.

Top module: `bus_park_arbiter`

## Requirements
- R1: During reset and after its release, with no requests present, the bus is parked on the on-chip side: `int_gnt_o`=1, `bg_o`=0, `bb_drv_o`=0, `retry_o`=0.
- R2: While parked, an on-chip request sampled with `bus_busy_in`=0 and no winning external request sets `bb_drv_o`=1 one cycle later, with no grant phase.
- R3: While parked, an on-chip request sampled with `bus_busy_in`=1 leaves `bb_drv_o` at 0 in the next cycle.
- R4: An external request (`ext_bus_req`=1) sampled while no on-chip request is present gives `bg_o`=1 one cycle later, whatever the value of `ext_prio_cfg`, including 0.
- R5: While the on-chip side drives the bus for a request, an external request wins (`bg_o`=1 next cycle) only when `ext_prio_cfg` is strictly greater than the access rank (3 when `int_is_data`=0, 4 when `int_is_data`=1). When the values are equal or lower, `bg_o` stays 0.
- R6: While the on-chip side drives the bus with `int_atomic`=1 and no retry, `bb_drv_o` stays 1 and `bg_o` stays 0, even against `ext_prio_cfg`=7.
- R7: One cycle after `int_retry` is sampled while the on-chip side drives the bus, `bb_drv_o`=0, `int_gnt_o`=0 and `bg_o`=1. In the following cycle, ownership follows normal parked arbitration.
- R8: Once granted, the external side keeps `bg_o`=1 while `bus_busy_in`=1, and also while no on-chip request wins it back (it stays parked).
- R9: While the external side holds the grant, `bus_busy_in`=0 together with an on-chip request gives `bg_o`=0 and `int_gnt_o`=1 one cycle later. This applies when `ext_bus_req`=0 or when `ext_prio_cfg` is not above the access rank.
- R10: While the external side holds the grant, `ext_hits_int`=1 together with a pending on-chip request makes `retry_o` high for exactly one clock, even if that condition persists.
- R11: `bg_o` and `int_gnt_o` are never high together, and `bb_drv_o` is high only when `int_gnt_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req | input | 1 | On-chip access needs the external bus |
| int_is_data | input | 1 | 1: data access (rank 4), 0: instruction access (rank 3) |
| int_atomic | input | 1 | Current on-chip sequence must not be interrupted |
| int_retry | input | 1 | Current on-chip transfer was retried by the slave |
| ext_bus_req | input | 1 | External master requests the bus |
| bus_busy_in | input | 1 | Bus busy line as seen from outside |
| ext_prio_cfg | input | PRIO_W | Programmable external priority, 0 to 7 |
| ext_hits_int | input | 1 | External master's access targets on-chip space |
| bg_o | output | 1 | Bus grant to the external master |
| int_gnt_o | output | 1 | On-chip side owns or is parked on the bus |
| bb_drv_o | output | 1 | On-chip side drives the busy line |
| retry_o | output | 1 | One-clock retry to the external master |

## Verification
The bench builds the block with its default parameters: a 3-bit external priority and on-chip ranks 0, 3 and 4. This makes every external priority value reachable, including the boundaries where it equals or exceeds each access rank by one. Directed steps walk through parking, the busy wait, atomic holding, the retry hand-off, the external-retry pulse and the take-back. A long seeded random run then mixes in the retry and atomic flags, so that hand-offs occur from every ownership state.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_PARK    = 2'd0,
    OWN_INT     = 2'd1,
    OWN_RELEASE = 2'd2,
    OWN_EXT     = 2'd3
  } own_state_e;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/arb_prio_cmp.sv
module arb_prio_cmp #(
  parameter int PRIO_W    = 3,
  parameter int PRIO_PARK = 0,
  parameter int PRIO_INSN = 3,
  parameter int PRIO_DATA = 4
) (
  input  logic              int_req,
  input  logic              int_is_data,
  input  logic              ext_req,
  input  logic [PRIO_W-1:0] ext_prio,
  output logic [PRIO_W-1:0] int_prio,
  output logic              ext_win,
  output logic              int_back
);
  localparam logic [PRIO_W-1:0] P_PARK = PRIO_W'(PRIO_PARK);
  localparam logic [PRIO_W-1:0] P_INSN = PRIO_W'(PRIO_INSN);
  localparam logic [PRIO_W-1:0] P_DATA = PRIO_W'(PRIO_DATA);

  always_comb begin
    if (!int_req)         int_prio = P_PARK;
    else if (int_is_data) int_prio = P_DATA;
    else                  int_prio = P_INSN;
  end

  // External side wins on a strictly higher rank, or when on-chip is idle.
  assign ext_win  = ext_req && (!int_req || (ext_prio > int_prio));
  assign int_back = int_req && (!ext_req || (ext_prio <= int_prio));
endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       int_req,
  input  logic       int_atomic,
  input  logic       int_retry,
  input  logic       bus_busy_in,
  input  logic       ext_win,
  input  logic       int_back,
  output own_state_e state,
  output logic       bg,
  output logic       int_gnt,
  output logic       bb_drv
);
  own_state_e state_q, state_nxt;
  logic       state_en;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      OWN_PARK, OWN_RELEASE: begin
        if (ext_win)                      state_nxt = OWN_EXT;
        else if (int_req && !bus_busy_in) state_nxt = OWN_INT;
        else                              state_nxt = OWN_PARK;
      end
      OWN_INT: begin
        if (int_retry)                    state_nxt = OWN_RELEASE;
        else if (ext_win && !int_atomic)  state_nxt = OWN_EXT;
        else if (!int_req && !int_atomic) state_nxt = OWN_PARK;
        else                              state_nxt = OWN_INT;
      end
      OWN_EXT: begin
        if (!bus_busy_in && int_back)     state_nxt = OWN_PARK;
        else                              state_nxt = OWN_EXT;
      end
      default:                            state_nxt = OWN_PARK;
    endcase
  end

  assign state_en = (state_nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= OWN_PARK;
    else if (state_en) state_q <= state_nxt;
  end

  assign state   = state_q;
  assign bg      = (state_q == OWN_EXT) || (state_q == OWN_RELEASE);
  assign int_gnt = (state_q == OWN_PARK) || (state_q == OWN_INT);
  assign bb_drv  = (state_q == OWN_INT);

  AST_PARK_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_PARK && int_req && !bus_busy_in && !ext_win) |=> bb_drv); // R2
  AST_BUSY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_PARK && bus_busy_in) |=> !bb_drv); // R3
  AST_ATOMIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_INT && int_atomic && !int_retry) |=> (bb_drv && !bg)); // R6
  AST_RETRY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_INT && int_retry) |=> (bg && !bb_drv && !int_gnt)); // R7
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_EXT && bus_busy_in) |=> bg); // R8
endmodule

// File: rtl/arb_retry_gen.sv
module arb_retry_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_owns,
  input  logic ext_hits_int,
  input  logic int_req,
  output logic retry
);
  logic retry_q, retry_nxt, clash;

  assign clash     = ext_owns && ext_hits_int && int_req;
  assign retry_nxt = clash && !retry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) retry_q <= 1'b0;
    else        retry_q <= retry_nxt;
  end

  assign retry = retry_q;

  AST_RETRY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q |=> !retry_q); // R10
  AST_RETRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_q) |-> $past(ext_owns && ext_hits_int && int_req)); // R10
endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter
  import arb_pkg::*;
#(
  parameter int PRIO_W    = 3,
  parameter int PRIO_PARK = 0,
  parameter int PRIO_INSN = 3,
  parameter int PRIO_DATA = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_req,
  input  logic              int_is_data,
  input  logic              int_atomic,
  input  logic              int_retry,
  input  logic              ext_bus_req,
  input  logic              bus_busy_in,
  input  logic [PRIO_W-1:0] ext_prio_cfg,
  input  logic              ext_hits_int,
  output logic              bg_o,
  output logic              int_gnt_o,
  output logic              bb_drv_o,
  output logic              retry_o
);
  logic              rst_n_s;
  logic [PRIO_W-1:0] int_prio;
  logic              ext_win, int_back;
  own_state_e        own;

  arb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  arb_prio_cmp #(
    .PRIO_W(PRIO_W), .PRIO_PARK(PRIO_PARK),
    .PRIO_INSN(PRIO_INSN), .PRIO_DATA(PRIO_DATA)
  ) u_cmp (
    .int_req(int_req), .int_is_data(int_is_data), .ext_req(ext_bus_req),
    .ext_prio(ext_prio_cfg), .int_prio(int_prio),
    .ext_win(ext_win), .int_back(int_back)
  );

  arb_owner_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .int_req(int_req), .int_atomic(int_atomic),
    .int_retry(int_retry), .bus_busy_in(bus_busy_in), .ext_win(ext_win),
    .int_back(int_back), .state(own), .bg(bg_o), .int_gnt(int_gnt_o),
    .bb_drv(bb_drv_o)
  );

  arb_retry_gen u_rty (
    .clk(clk), .rst_n(rst_n_s), .ext_owns(own == OWN_EXT),
    .ext_hits_int(ext_hits_int), .int_req(int_req), .retry(retry_o)
  );

  AST_LOW_PRIO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bb_drv_o && int_req && !int_retry && (ext_prio_cfg <= int_prio)) |=> !bg_o); // R5
  AST_IDLE_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!bg_o && ext_bus_req && !int_req && !int_atomic && !int_retry) |=> bg_o); // R4
  AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(bg_o && int_gnt_o) && (!bb_drv_o || int_gnt_o)); // R11
  AST_TAKE_BACK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bg_o && !bb_drv_o && !int_gnt_o && own == OWN_EXT && !bus_busy_in && int_req
     && (!ext_bus_req || ext_prio_cfg <= int_prio)) |=> (int_gnt_o && !bg_o)); // R9
endmodule

// File: tb/tb_bus_park_arbiter.sv
`timescale 1ns/1ps
module tb_bus_park_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_req = 0, int_is_data = 0, int_atomic = 0, int_retry = 0;
  logic ext_bus_req = 0, bus_busy_in = 0, ext_hits_int = 0;
  logic [2:0] ext_prio_cfg = 3'd0;
  logic bg_o, int_gnt_o, bb_drv_o, retry_o;

  int checks = 0, errors = 0;
  int m_own = 0;      // 0 parked, 1 on-chip, 2 forced release, 3 external
  bit m_rty = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_park_arbiter dut (
    .clk(clk), .rst_n(rst_n), .int_req(int_req), .int_is_data(int_is_data),
    .int_atomic(int_atomic), .int_retry(int_retry), .ext_bus_req(ext_bus_req),
    .bus_busy_in(bus_busy_in), .ext_prio_cfg(ext_prio_cfg),
    .ext_hits_int(ext_hits_int), .bg_o(bg_o), .int_gnt_o(int_gnt_o),
    .bb_drv_o(bb_drv_o), .retry_o(retry_o)
  );

  function automatic int rank();
    if (!int_req) return 0;
    return int_is_data ? 4 : 3;
  endfunction

  function automatic bit ext_wins();
    return ext_bus_req && (!int_req || int'(ext_prio_cfg) > rank());
  endfunction

  function automatic bit int_wins();
    return int_req && (!ext_bus_req || int'(ext_prio_cfg) <= rank());
  endfunction

  function automatic logic [3:0] expect_vec();
    return {(m_own == 2 || m_own == 3), (m_own <= 1), (m_own == 1), m_rty};
  endfunction

  task automatic model_step();
    int nxt;
    bit rn;
    rn = (m_own == 3) && ext_hits_int && int_req && !m_rty;
    case (m_own)
      1: if (int_retry) nxt = 2;
         else if (ext_wins() && !int_atomic) nxt = 3;
         else if (!int_req && !int_atomic) nxt = 0;
         else nxt = 1;
      3: nxt = (!bus_busy_in && int_wins()) ? 0 : 3;
      default: if (ext_wins()) nxt = 3;
               else if (int_req && !bus_busy_in) nxt = 1;
               else nxt = 0;
    endcase
    m_own = nxt;
    m_rty = rn;
  endtask

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {bg,gnt,bbd,rty} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(bit rq, bit dt, bit at, bit rt, bit br, bit bz,
                     int ep, bit hi, string tag);
    @(negedge clk);
    int_req = rq; int_is_data = dt; int_atomic = at; int_retry = rt;
    ext_bus_req = br; bus_busy_in = bz; ext_prio_cfg = 3'(ep); ext_hits_int = hi;
    @(posedge clk);
    model_step();
    #1;
    check(tag, {bg_o, int_gnt_o, bb_drv_o, retry_o}, expect_vec());
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    check("R1 in reset", {bg_o, int_gnt_o, bb_drv_o, retry_o}, 4'b0100);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1 after release");
    // directed corners
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R2 parked start");
    cyc(1, 0, 1, 0, 1, 0, 7, 0, "R6 atomic holds vs prio 7");
    cyc(1, 0, 0, 0, 1, 0, 3, 0, "R5 equal rank blocked");
    cyc(1, 1, 0, 0, 1, 0, 4, 0, "R5 equal data rank blocked");
    cyc(1, 0, 0, 0, 1, 0, 4, 0, "R5 higher rank wins");
    cyc(1, 1, 0, 0, 0, 1, 0, 0, "R8 ext keeps while busy");
    cyc(1, 1, 0, 0, 0, 1, 0, 1, "R10 retry pulse");
    cyc(1, 1, 0, 0, 0, 1, 0, 1, "R10 single clock");
    cyc(1, 1, 0, 0, 0, 0, 0, 0, "R9 take back idle ext");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, "R3 wait on busy");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R2 start after busy");
    cyc(1, 0, 0, 1, 0, 0, 0, 0, "R7 forced release");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R7 normal after release");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R4 idle ext prio 0");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8 ext parked");
    cyc(1, 1, 0, 0, 1, 0, 4, 0, "R9 take back equal rank");
    // seeded random mix
    for (int i = 0; i < 3000; i++) begin
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3) == 0,
          $urandom_range(0, 15) == 0, $urandom_range(0, 1), $urandom_range(0, 2) == 0,
          $urandom_range(0, 7), $urandom_range(0, 3) == 0, "R11 random model");
      checks++;
      if ((bg_o && int_gnt_o) || (bb_drv_o && !int_gnt_o)) begin
        errors++;
        $display("FAIL R11: bg %b gnt %b bbd %b expected exclusive", bg_o, int_gnt_o, bb_drv_o);
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule